// File: doc/BRIEF.md
# Watchdog and interval timer

This block is an 8-bit up-counter advanced by ticks from a free-running prescaler, steered by one control/status register. A 3-bit clock select picks one of eight divide ratios for the ticks. When the counter wraps from 0xFF to 0x00, one of two things happens, depending on a mode bit. In interval mode a sticky overflow flag is set, and that flag is the interrupt request. In watchdog mode a single-cycle overflow pulse is sent out for the reset logic of the chip, and the flag is left alone.

Software reaches the block over a small register bus. Address 0 holds the control/status register and address 1 holds the counter. Every write carries a key byte in the upper half of the 16-bit write word, and a write with the wrong key is dropped, so a runaway program cannot easily reprogram or feed the watchdog. The overflow flag can only be cleared by reading it as 1 first and then writing 0 to it.

Top module: `wdog_itimer`

## Requirements
- R1: After reset the control/status register reads 0x18, the counter reads 0x00, and irq and wdt_ovf are low. The internal reset is released on the second rising clock edge after rst_n goes high, and state first advances on the third.
- R2: A write to address 0 takes effect only when wr_data[15:8] is 0xA5. A write to address 1 takes effect only when wr_data[15:8] is 0x5A. The data is in wr_data[7:0]. Any other write, or any write to another address, changes nothing.
- R3: In the control/status register, bit 6 is the mode (1 = watchdog, 0 = interval), bit 5 is the run enable, and bits 2:0 are the clock select. Bits 4:3 always read as 1, and writes to them are ignored.
- R4: Clock select codes 0 to 7 give a counter tick once every 2, 64, 128, 512, 2048, 8192, 32768 and 131072 clocks of a free-running prescaler. The prescaler starts at zero at reset, and a tick falls on each clock where the prescaler count modulo the ratio equals the ratio minus one.
- R5: While the run enable is 0, the counter is held at 0x00 and counter writes are ignored.
- R6: In interval mode, a counter wrap from 0xFF to 0x00 sets the overflow flag (bit 7) on the same edge. The irq output equals the flag.
- R7: In watchdog mode a wrap never sets the flag. It drives wdt_ovf high for exactly one clock, starting on the edge at which the counter becomes 0x00.
- R8: The flag is cleared by a keyed control write with bit 7 = 0, but only if a read of address 0 has returned the flag as 1 since the last accepted control write. Writing 1 to bit 7 leaves the flag unchanged. A new overflow on the same edge as a clear wins.
- R9: An accepted counter write loads the counter and takes priority over a tick on the same edge. A loaded 0xFF wraps on the next tick.
- R10: rd_data is 0x00 whenever rd_en is low or the address is neither 0 nor 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 control/status, 1 counter |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (also arms the flag clear) |
| wr_data | input | 16 | Key byte in [15:8], data in [7:0] |
| rd_data | output | 8 | Read data, combinational from addr and rd_en |
| irq | output | 1 | Interval interrupt request (the overflow flag) |
| wdt_ovf | output | 1 | Watchdog overflow pulse, one clock wide |

## Verification
The assertions assume three things about the inputs: they are known and steady around each rising edge, the mode, enable and select fields change only through keyed control writes, and a flag clear is always a control write in the cycle before irq falls. The stimulus changes every input on the falling edge and keeps the address within the two mapped registers plus deliberate probes of the unmapped ones. It sends writes with the correct key, the other register's key and a null key. The long-ratio clock selects are exercised by loading 0xFF into the counter, so every wrap arrives within one tick period instead of 256.

// File: rtl/wit_pkg.sv
package wit_pkg;
  localparam int CNT_W   = 8;
  localparam int CSR_W   = 8;
  localparam int WDATA_W = 16;
  localparam int KEY_W   = WDATA_W - CSR_W;
  localparam int CKS_W   = 3;
  localparam int NUM_SEL = 1 << CKS_W;
  localparam int PRE_W   = 17;

  localparam logic [KEY_W-1:0] KEY_CSR = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_CNT = 8'h5A;

  // Control/status register layout, most significant bit first
  typedef struct packed {
    logic             ovf;
    logic             wdog;
    logic             run;
    logic [1:0]       rsvd;
    logic [CKS_W-1:0] sel;
  } csr_t;

  localparam logic [1:0] RSVD_VAL = 2'b11;

  // log2 of the divide ratio for each clock select code
  function automatic int sel_bits(input int code);
    case (code)
      0:       return 1;
      1:       return 6;
      2:       return 7;
      3:       return 9;
      4:       return 11;
      5:       return 13;
      6:       return 15;
      default: return 17;
    endcase
  endfunction
endpackage

// File: rtl/wit_rst_sync.sv
module wit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wit_prescaler.sv
module wit_prescaler
  import wit_pkg::*;
#(
  parameter int P_W = PRE_W,
  parameter int S_W = CKS_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [S_W-1:0] sel,
  output logic           tick
);
  localparam int TAPS = 1 << S_W;

  logic [P_W-1:0]  pre_q;
  logic [P_W-1:0]  pre_d;
  logic [TAPS-1:0] tap;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // One tap per clock select code: high when the low bits are all ones
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    localparam int B = sel_bits(g);
    assign tap[g] = &pre_q[B-1:0];
  end

  assign tick = tap[sel];
endmodule

// File: rtl/wit_counter.sv
module wit_counter
  import wit_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // a load wins over a tick, so a load never wraps
  assign wrap   = run && !load && tick && (&cnt_q);
  assign cnt_en = !run || load || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wit_regs.sv
module wit_regs
  import wit_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CSR_ADDR = 0,
  parameter int CNT_ADDR = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [WDATA_W-1:0] wr_data,
  input  logic               wrap,
  input  logic [CNT_W-1:0]   cnt_q,
  output logic               run_q,
  output logic               wdog_q,
  output logic [CKS_W-1:0]   sel_q,
  output logic               load,
  output logic [CNT_W-1:0]   load_val,
  output logic [CSR_W-1:0]   rd_data,
  output logic               flag_q,
  output logic               pulse_q
);
  logic [KEY_W-1:0] key;
  csr_t             body;
  logic             hit_csr, hit_cnt;
  logic             csr_wr;
  logic             arm_q, arm_d;
  logic             run_d, wdog_d, flag_d, pulse_d;
  logic [CKS_W-1:0] sel_d;
  logic             ctl_en;
  csr_t             csr_view;

  assign key     = wr_data[WDATA_W-1 -: KEY_W];
  assign body    = csr_t'(wr_data[CSR_W-1:0]);
  assign hit_csr = (addr == ADDR_W'(CSR_ADDR));
  assign hit_cnt = (addr == ADDR_W'(CNT_ADDR));

  assign csr_wr   = wr_en && hit_csr && (key == KEY_CSR);
  assign load     = wr_en && hit_cnt && (key == KEY_CNT) && run_q;
  assign load_val = wr_data[CNT_W-1:0];

  // Mode, enable and select fields
  assign ctl_en = csr_wr;
  always_comb begin
    run_d  = run_q;
    wdog_d = wdog_q;
    sel_d  = sel_q;
    if (csr_wr) begin
      run_d  = body.run;
      wdog_d = body.wdog;
      sel_d  = body.sel;
    end
  end

  // Clear arming: a read that sees the flag set, dropped by any control write
  always_comb begin
    arm_d = arm_q;
    if (csr_wr)                         arm_d = 1'b0;
    else if (rd_en && hit_csr && flag_q) arm_d = 1'b1;
  end

  // Overflow flag: a new overflow beats a clear on the same edge
  always_comb begin
    flag_d = flag_q;
    if (wrap && !wdog_q)                       flag_d = 1'b1;
    else if (csr_wr && arm_q && !body.ovf)     flag_d = 1'b0;
  end

  assign pulse_d = wrap && wdog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wdog_q <= 1'b0;
      sel_q  <= '0;
    end else if (ctl_en) begin
      run_q  <= run_d;
      wdog_q <= wdog_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      arm_q   <= arm_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  // Read view
  always_comb begin
    csr_view      = '0;
    csr_view.ovf  = flag_q;
    csr_view.wdog = wdog_q;
    csr_view.run  = run_q;
    csr_view.rsvd = RSVD_VAL;
    csr_view.sel  = sel_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (hit_csr)      rd_data = csr_view;
      else if (hit_cnt) rd_data = cnt_q;
    end
  end
endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
  import wit_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CSR_ADDR = 0,
  parameter int CNT_ADDR = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [WDATA_W-1:0] wr_data,
  output logic [CSR_W-1:0]   rd_data,
  output logic               irq,
  output logic               wdt_ovf
);
  logic             rst_sync_n;
  logic             tick;
  logic             wrap;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, wdog_q;
  logic [CKS_W-1:0] sel_q;
  logic             flag_q, pulse_q;

  wit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wit_prescaler #(.P_W(PRE_W), .S_W(CKS_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sel   (sel_q),
    .tick  (tick)
  );

  wit_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run_q),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .cnt_q    (cnt_q),
    .wrap     (wrap)
  );

  wit_regs #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .CNT_ADDR(CNT_ADDR)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .wrap     (wrap),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .wdog_q   (wdog_q),
    .sel_q    (sel_q),
    .load     (load),
    .load_val (load_val),
    .rd_data  (rd_data),
    .flag_q   (flag_q),
    .pulse_q  (pulse_q)
  );

  assign irq     = flag_q;
  assign wdt_ovf = pulse_q;
endmodule

// File: rtl/wdog_itimer_chk.sv
module wdog_itimer_chk
  import wit_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CSR_ADDR = 0
) (
  input logic               clk,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic               rd_en,
  input logic [WDATA_W-1:0] wr_data,
  input logic [CSR_W-1:0]   rd_data,
  input logic               irq,
  input logic               wdt_ovf,
  input logic               wdog,
  input logic               run,
  input logic [CKS_W-1:0]   sel,
  input logic [CNT_W-1:0]   cnt
);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    wdt_ovf |=> !wdt_ovf);

  assert_pulse_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    wdt_ovf |-> (cnt == '0) && $past(wdog));

  assert_flag_interval_only_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> !$past(wdog));

  assert_flag_clear_keyed_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(irq) |-> $past(wr_en && (addr == ADDR_W'(CSR_ADDR)) &&
                         (wr_data[WDATA_W-1 -: KEY_W] == KEY_CSR) && !wr_data[CSR_W-1]));

  assert_bad_key_ignored_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (addr == ADDR_W'(CSR_ADDR)) && (wr_data[WDATA_W-1 -: KEY_W] != KEY_CSR))
    |=> $stable(wdog) && $stable(run) && $stable(sel));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> (cnt == '0));

  assert_reserved_ones_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && (addr == ADDR_W'(CSR_ADDR))) |-> (rd_data[4:3] == 2'b11));

  assert_no_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |-> (rd_data == '0));
endmodule

bind wdog_itimer wdog_itimer_chk #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_sync_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq     (irq),
  .wdt_ovf (wdt_ovf),
  .wdog    (wdog_q),
  .run     (run_q),
  .sel     (sel_q),
  .cnt     (cnt_q)
);

// File: tb/wdog_itimer_test.sv
module wdog_itimer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr_en, rd_en;
  logic [15:0] wr_data;
  logic [7:0]  rd_data;
  logic        irq, wdt_ovf;

  always #10 clk = ~clk;

  wdog_itimer uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .wdt_ovf(wdt_ovf)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    pulses = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int         m_rel, m_pre, m_div;
  logic [7:0] m_cnt;
  logic [2:0] m_sel;
  logic       m_flag, m_wd, m_run, m_armed, m_wdt;
  logic       t_tick, t_cw, t_nw, t_ov;

  function automatic int div_of(input logic [2:0] s);
    int table_v[8] = '{2, 64, 128, 512, 2048, 8192, 32768, 131072};
    return table_v[s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_pre = 0; m_cnt = 8'h00; m_sel = 3'd0;
      m_flag = 0; m_wd = 0; m_run = 0; m_armed = 0; m_wdt = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      m_div  = div_of(m_sel);
      t_tick = ((m_pre % m_div) == m_div - 1);
      t_cw   = wr_en && addr == 2'd0 && wr_data[15:8] == 8'hA5;
      t_nw   = wr_en && addr == 2'd1 && wr_data[15:8] == 8'h5A && m_run;
      t_ov   = m_run && !t_nw && t_tick && m_cnt == 8'hFF;
      m_wdt  = t_ov && m_wd;
      if (t_ov && !m_wd) m_flag = 1'b1;
      else if (t_cw && m_armed && !wr_data[7]) m_flag = 1'b0;
      if (t_cw) m_armed = 1'b0;
      else if (rd_en && addr == 2'd0 && m_flag_prev_set()) m_armed = 1'b1;
      if (!m_run)      m_cnt = 8'h00;
      else if (t_nw)   m_cnt = wr_data[7:0];
      else if (t_tick) m_cnt = m_cnt + 8'd1;
      if (t_cw) begin
        m_wd = wr_data[6]; m_run = wr_data[5]; m_sel = wr_data[2:0];
      end
      m_pre = (m_pre + 1) % 131072;
    end
  end

  // flag value before this edge's update, kept for the arming rule (R8)
  logic m_flag_old;
  always @(negedge clk) m_flag_old = m_flag;
  function automatic logic m_flag_prev_set();
    return m_flag_old;
  endfunction

  function automatic logic [7:0] exp_rd();
    if (!rd_en) return 8'h00;
    if (addr == 2'd0) return {m_flag, m_wd, m_run, 2'b11, m_sel};
    if (addr == 2'd1) return m_cnt;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && wdt_ovf) pulses++;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected<%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input logic we, input logic re, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wr_data = d;
    #1;
    chk(cur_req, "rd_data", rd_data, exp_rd());
    chk(cur_req, "irq", irq, m_flag);
    chk(cur_req, "wdt_ovf", wdt_ovf, m_wdt);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 16'h0000);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    step(1'b0, 1'b1, a, 16'h0000);
    v = rd_data;
  endtask

  logic [7:0] v, v0;

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
    idle(5);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    cur_req = "R1";
    rd(2'd0, v); chk("R1", "csr after reset", v, 8'h18);
    rd(2'd1, v); chk("R1", "count after reset", v, 8'h00);
    chk("R1", "irq after reset", irq, 1'b0);

    cur_req = "R2";
    step(1'b1, 1'b0, 2'd0, 16'h0027);
    step(1'b1, 1'b0, 2'd0, 16'h5A27);
    step(1'b1, 1'b0, 2'd2, 16'hA527);
    rd(2'd0, v); chk("R2", "csr after bad keys", v, 8'h18);

    cur_req = "R4";
    step(1'b1, 1'b0, 2'd0, 16'hA521);
    rd(2'd0, v); chk("R3", "csr fields", v, 8'h39);
    rd(2'd1, v0);
    idle(639);
    rd(2'd1, v); chk("R4", "ticks in 640 clocks at ratio 64", v - v0, 8'd10);

    cur_req = "R9";
    step(1'b1, 1'b0, 2'd0, 16'hA520);
    step(1'b1, 1'b0, 2'd1, 16'hA5F0);
    rd(2'd1, v); chk("R2", "counter bad key", v < 8'hF0, 1'b1);
    step(1'b1, 1'b0, 2'd1, 16'h5AF0);
    rd(2'd1, v); chk("R9", "counter load", v, 8'hF0);
    cur_req = "R6";
    idle(60);
    chk("R6", "irq after interval wrap", irq, 1'b1);
    chk("R6", "no pulse in interval mode", pulses, 0);

    cur_req = "R8";
    step(1'b1, 1'b0, 2'd0, 16'hA520);
    idle(1); chk("R8", "clear without read", irq, 1'b1);
    rd(2'd0, v); chk("R8", "flag reads 1", v[7], 1'b1);
    step(1'b1, 1'b0, 2'd0, 16'hA5A0);
    idle(1); chk("R8", "write 1 keeps flag", irq, 1'b1);
    step(1'b1, 1'b0, 2'd0, 16'hA520);
    idle(1); chk("R8", "arming dropped by write", irq, 1'b1);
    rd(2'd0, v);
    step(1'b1, 1'b0, 2'd0, 16'hA520);
    idle(1); chk("R8", "read then write 0 clears", irq, 1'b0);

    cur_req = "R5";
    step(1'b1, 1'b0, 2'd0, 16'hA500);
    idle(3);
    rd(2'd1, v); chk("R5", "count held when stopped", v, 8'h00);
    step(1'b1, 1'b0, 2'd1, 16'h5A33);
    idle(2);
    rd(2'd1, v); chk("R5", "load ignored when stopped", v, 8'h00);

    cur_req = "R7";
    pulses = 0;
    step(1'b1, 1'b0, 2'd0, 16'hA561);
    step(1'b1, 1'b0, 2'd1, 16'h5AFE);
    idle(200);
    chk("R7", "watchdog pulses", pulses, 1);
    chk("R7", "irq in watchdog mode", irq, 1'b0);
    rd(2'd0, v); chk("R7", "flag bit in watchdog mode", v[7], 1'b0);
    step(1'b1, 1'b0, 2'd0, 16'hA500);

    cur_req = "R4";
    for (int s = 2; s <= 6; s++) begin
      step(1'b1, 1'b0, 2'd0, 16'hA520 | 16'(s));
      step(1'b1, 1'b0, 2'd1, 16'h5AFF);
      idle(div_of(3'(s)) + 8);
      chk("R4", $sformatf("wrap at select %0d", s), irq, 1'b1);
      rd(2'd0, v);
      step(1'b1, 1'b0, 2'd0, 16'hA500);
      idle(1);
    end
    step(1'b1, 1'b0, 2'd0, 16'hA527);
    idle(3000);
    rd(2'd1, v);

    cur_req = "R10";
    step(1'b0, 1'b0, 2'd1, 16'h0000); chk("R10", "no read strobe", rd_data, 8'h00);
    step(1'b0, 1'b1, 2'd2, 16'h0000); chk("R10", "address 2", rd_data, 8'h00);
    step(1'b0, 1'b1, 2'd3, 16'h0000); chk("R10", "address 3", rd_data, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule